// File: doc/BRIEF.md
# DMA Byte-Count and Burst Sequencer

This block sits on the device side of a full-speed USB peripheral, between the local command port and an external DMA controller. Software loads a transfer length, in bytes, into a 16-bit count register and then writes a configuration byte. That byte carries an enable flag and a burst-size selector. Each enable copies the programmed length into a separate live down-counter. From then on the block raises a request line for one burst at a time. Every acknowledged byte takes one off the live count.

A transfer ends in one of two ways. It ends on its own when the live count reaches zero, or it ends when software writes the enable flag back to 0. Either way a sticky end-of-transfer interrupt is raised and held until it is cleared. A USB bus reset turns the enable flag off but keeps the programmed length and the burst selector. The command port takes a command byte and then data bytes. Multi-byte values move least significant byte first. Reading the count gives the bytes still outstanding in the live counter, not the programmed value.

Top module: `dmaseq_top`

## Requirements
- R1: After reset, `dma_req` and `eot_irq` are 0, the configuration read (command F1h) returns 00h, and the count read (command F3h) returns 0000h.
- R2: Command F2h followed by two data writes loads the programmed count, low byte (bits 7..0) first and high byte (bits 15..8) second. The value becomes visible through the count read right after the next enable.
- R3: Command F3h followed by two data reads returns the live remaining byte count, low byte first and then high byte, with `dat_re` advancing to the next byte.
- R4: Command F0h followed by one data write sets the configuration: bit 3 is the enable flag and bits 1..0 are the burst selector. Command F1h reads back {4'b0, enable, 1'b0, burst}.
- R5: Every write of the enable flag as 1 reloads the live counter from the programmed count, including a write made while a transfer is running. That write raises no interrupt.
- R6: The burst selector gives 1, 4, 8 or 16 bytes per request for codes 00, 01, 10 and 11. `dma_req` stays high for exactly that many acknowledges and then drops for at least one cycle.
- R7: When fewer bytes remain than the burst size, the remaining bytes are requested one byte per request.
- R8: Each cycle with both `dma_req` and `dma_ack` high moves one byte and decrements the live count by one. `dma_ack` while `dma_req` is low, including while disabled, leaves the count unchanged.
- R9: In the cycle after the live count is zero with the enable flag set, the enable flag clears, `dma_req` stays low and `eot_irq` sets. An enable with a programmed count of zero therefore ends without any request.
- R10: Writing the enable flag as 0 during a transfer stops it and sets `eot_irq`. The same write while already stopped sets nothing.
- R11: `eot_irq` stays set until an `irq_clr` pulse clears it.
- R12: A `bus_rst` pulse clears the enable flag and `dma_req` without raising `eot_irq`. It leaves the programmed count and the burst selector unchanged.
- R13: A count write during a running transfer leaves the live counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rst | input | 1 | USB bus reset pulse |
| cmd_we | input | 1 | Command byte strobe; also restarts the byte pointer |
| cmd_code | input | 8 | Command byte |
| dat_we | input | 1 | Data write strobe |
| dat_in | input | 8 | Data byte written |
| dat_re | input | 1 | Data read strobe, advances to the next byte |
| dat_out | output | 8 | Data byte selected by the current read command |
| dma_req | output | 1 | Byte request towards the DMA controller |
| dma_ack | input | 1 | One byte moved in this cycle |
| eot_irq | output | 1 | Sticky end-of-transfer interrupt |
| irq_clr | input | 1 | Clears `eot_irq` |

## Verification
The bench sweeps every burst code against every transfer length from 0 to 40 and compares each request run with a length computed arithmetically. A design that got the tail fallback wrong would issue a short burst or overrun the count. A design that failed to drop the request between bursts would show merged runs. Lengths of zero and exact burst multiples catch an end-of-transfer that fires early, late or not at all. Directed cases re-enable mid-transfer, rewrite the count while running, acknowledge while stopped, stop from software twice, and pulse bus reset. A design that reloaded on a count write, counted stray acknowledges, raised the interrupt on a redundant stop or on bus reset, or lost the burst selector would fail one of them.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

   localparam logic [7:0] CMD_CFG_WR = 8'hF0;
   localparam logic [7:0] CMD_CFG_RD = 8'hF1;
   localparam logic [7:0] CMD_CNT_WR = 8'hF2;
   localparam logic [7:0] CMD_CNT_RD = 8'hF3;

   localparam int EN_BIT   = 3;
   localparam int MAX_BURST = 16;

   typedef enum logic [1:0] {
      BL_1  = 2'b00,
      BL_4  = 2'b01,
      BL_8  = 2'b10,
      BL_16 = 2'b11
   } burst_e;

   function automatic int unsigned burst_bytes(burst_e b);
      case (b)
         BL_1:    return 1;
         BL_4:    return 4;
         BL_8:    return 8;
         default: return 16;
      endcase
   endfunction

endpackage

// File: rtl/dmaseq_regs.sv
module dmaseq_regs
   import dmaseq_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic [7:0]       cmd_code,
   input  logic             dat_we,
   input  logic [7:0]       dat_in,
   input  logic             dat_re,
   input  logic             en,
   input  logic [CNT_W-1:0] live,
   output logic [CNT_W-1:0] cnt_prog,
   output burst_e           burst,
   output logic             cfg_wr,
   output logic             cfg_en,
   output logic [7:0]       dat_out
);

   localparam int NB = CNT_W / 8;
   localparam int PW = $clog2(NB + 1);

   logic [7:0]    cur_cmd;
   logic [PW-1:0] ptr;
   logic          wr_ok;
   logic          cnt_wr;
   logic          cnt_rd;

   assign wr_ok  = dat_we && !cmd_we;
   assign cnt_wr = wr_ok && (cur_cmd == CMD_CNT_WR);
   assign cnt_rd = dat_re && !cmd_we && (cur_cmd == CMD_CNT_RD);
   assign cfg_wr = wr_ok && (cur_cmd == CMD_CFG_WR);
   assign cfg_en = dat_in[EN_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_cmd <= '0;
         ptr     <= '0;
      end else if (cmd_we) begin
         cur_cmd <= cmd_code;
         ptr     <= '0;
      end else if ((cnt_wr || cnt_rd) && (ptr < PW'(NB))) begin
         ptr <= ptr + 1'b1;
      end
   end

   for (genvar g = 0; g < NB; g++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt_prog[8*g +: 8] <= '0;
         else if (cnt_wr && (ptr == PW'(g)))
            cnt_prog[8*g +: 8] <= dat_in;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         burst <= BL_1;
      else if (cfg_wr)
         burst <= burst_e'(dat_in[1:0]);
   end

   always_comb begin
      dat_out = '0;
      if (cur_cmd == CMD_CFG_RD) begin
         dat_out[EN_BIT] = en;
         dat_out[1:0]    = burst;
      end else if (cur_cmd == CMD_CNT_RD) begin
         for (int i = 0; i < NB; i++)
            if (ptr == PW'(i))
               dat_out = live[8*i +: 8];
      end
   end

endmodule

// File: rtl/dmaseq_engine.sv
module dmaseq_engine
   import dmaseq_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_rst,
   input  logic             cfg_wr,
   input  logic             cfg_en,
   input  logic [CNT_W-1:0] cnt_prog,
   input  burst_e           burst,
   input  logic             dma_ack,
   input  logic             irq_clr,
   output logic             en,
   output logic [CNT_W-1:0] live,
   output logic             dma_req,
   output logic             eot_irq
);

   localparam int BW = $clog2(MAX_BURST + 1);

   logic [BW-1:0] beats;
   logic [BW-1:0] size_b;
   logic [BW-1:0] step_b;
   logic          take;
   logic          end_sw;
   logic          end_auto;

   assign size_b   = BW'(burst_bytes(burst));
   assign step_b   = (live >= CNT_W'(size_b)) ? size_b : BW'(1);
   assign dma_req  = en && (beats != '0);
   assign take     = dma_req && dma_ack;
   assign end_sw   = !bus_rst && cfg_wr && !cfg_en && en;
   assign end_auto = !bus_rst && !cfg_wr && en && (beats == '0) && (live == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en    <= 1'b0;
         live  <= '0;
         beats <= '0;
      end else if (bus_rst) begin
         en    <= 1'b0;
         beats <= '0;
      end else if (cfg_wr) begin
         en    <= cfg_en;
         beats <= '0;
         if (cfg_en)
            live <= cnt_prog;
      end else if (en) begin
         if (take) begin
            live  <= live - 1'b1;
            beats <= beats - 1'b1;
         end else if (beats == '0) begin
            if (live == '0)
               en <= 1'b0;
            else
               beats <= step_b;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         eot_irq <= 1'b0;
      else if (end_sw || end_auto)
         eot_irq <= 1'b1;
      else if (irq_clr)
         eot_irq <= 1'b0;
   end

endmodule

// File: rtl/dmaseq_top.sv
module dmaseq_top
   import dmaseq_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_rst,
   input  logic       cmd_we,
   input  logic [7:0] cmd_code,
   input  logic       dat_we,
   input  logic [7:0] dat_in,
   input  logic       dat_re,
   output logic [7:0] dat_out,
   output logic       dma_req,
   input  logic       dma_ack,
   output logic       eot_irq,
   input  logic       irq_clr
);

   if ((CNT_W % 8 != 0) || (CNT_W < 8)) begin : g_bad_width
      $error("CNT_W must be a nonzero multiple of 8");
   end

   logic [CNT_W-1:0] cnt_prog;
   logic [CNT_W-1:0] live_q;
   burst_e           burst_q;
   logic             cfg_wr;
   logic             cfg_en;
   logic             en_q;

   dmaseq_regs #(.CNT_W(CNT_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_we   (cmd_we),
      .cmd_code (cmd_code),
      .dat_we   (dat_we),
      .dat_in   (dat_in),
      .dat_re   (dat_re),
      .en       (en_q),
      .live     (live_q),
      .cnt_prog (cnt_prog),
      .burst    (burst_q),
      .cfg_wr   (cfg_wr),
      .cfg_en   (cfg_en),
      .dat_out  (dat_out)
   );

   dmaseq_engine #(.CNT_W(CNT_W)) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_rst  (bus_rst),
      .cfg_wr   (cfg_wr),
      .cfg_en   (cfg_en),
      .cnt_prog (cnt_prog),
      .burst    (burst_q),
      .dma_ack  (dma_ack),
      .irq_clr  (irq_clr),
      .en       (en_q),
      .live     (live_q),
      .dma_req  (dma_req),
      .eot_irq  (eot_irq)
   );

endmodule

// File: rtl/dmaseq_chk.sv
module dmaseq_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_rst,
   input logic             dma_req,
   input logic             dma_ack,
   input logic             eot_irq,
   input logic             irq_clr,
   input logic             en,
   input logic [CNT_W-1:0] live,
   input logic [CNT_W-1:0] cnt_prog,
   input logic [1:0]       burst,
   input logic             cfg_wr,
   input logic             cfg_en,
   input logic             dat_we
);

   p_req_only_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> en);

   p_ack_takes_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req && dma_ack && !bus_rst && !cfg_wr) |=> (live == $past(live) - 1'b1));

   p_idle_keeps_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!dma_req && !cfg_wr) |=> $stable(live));

   p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_en && !bus_rst) |=> (en && live == $past(cnt_prog)));

   p_auto_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && live == '0 && !dma_req && !bus_rst && !cfg_wr) |=> (!en && !dma_req && eot_irq));

   p_sw_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cfg_wr && !cfg_en && !bus_rst) |=> (!en && eot_irq));

   p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (eot_irq && !irq_clr) |=> eot_irq);

   p_bus_rst_keeps_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rst && !dat_we) |=> (!en && !dma_req && $stable(burst) && $stable(cnt_prog)));

endmodule

bind dmaseq_top dmaseq_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_rst  (bus_rst),
   .dma_req  (dma_req),
   .dma_ack  (dma_ack),
   .eot_irq  (eot_irq),
   .irq_clr  (irq_clr),
   .en       (en_q),
   .live     (live_q),
   .cnt_prog (cnt_prog),
   .burst    (burst_q),
   .cfg_wr   (cfg_wr),
   .cfg_en   (cfg_en),
   .dat_we   (dat_we)
);

// File: tb/tb_dmaseq_top.sv
module tb_dmaseq_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_rst = 1'b0;
   logic       cmd_we = 1'b0;
   logic [7:0] cmd_code = '0;
   logic       dat_we = 1'b0;
   logic [7:0] dat_in = '0;
   logic       dat_re = 1'b0;
   logic [7:0] dat_out;
   logic       dma_req;
   logic       dma_ack = 1'b0;
   logic       eot_irq;
   logic       irq_clr = 1'b0;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   dmaseq_top dut (
      .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .cmd_we(cmd_we),
      .cmd_code(cmd_code), .dat_we(dat_we), .dat_in(dat_in), .dat_re(dat_re),
      .dat_out(dat_out), .dma_req(dma_req), .dma_ack(dma_ack),
      .eot_irq(eot_irq), .irq_clr(irq_clr)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cmd(input logic [7:0] c);
      @(negedge clk); cmd_we = 1'b1; cmd_code = c;
      @(negedge clk); cmd_we = 1'b0;
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk); dat_we = 1'b1; dat_in = d;
      @(negedge clk); dat_we = 1'b0;
   endtask

   task automatic rd(output logic [7:0] d);
      @(negedge clk); d = dat_out; dat_re = 1'b1;
      @(negedge clk); dat_re = 1'b0;
   endtask

   task automatic set_count(input int n);
      cmd(8'hF2); wr(8'(n)); wr(8'(n >> 8));
   endtask

   task automatic get_count(output int n);
      logic [7:0] lo, hi;
      cmd(8'hF3); rd(lo); rd(hi);
      n = {hi, lo};
   endtask

   task automatic set_cfg(input bit e, input int b);
      cmd(8'hF0); wr({4'b0, e, 1'b0, 2'(b)});
   endtask

   task automatic get_cfg(output logic [7:0] v);
      cmd(8'hF1); rd(v);
   endtask

   task automatic clear_irq();
      @(negedge clk); irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
   endtask

   task automatic ack_bytes(input int k);
      int got = 0;
      int guard = 0;
      while (got < k && guard < 200) begin
         @(negedge clk);
         dma_ack = dma_req;
         if (dma_req) got++;
         guard++;
      end
      @(negedge clk); dma_ack = 1'b0;
   endtask

   task automatic transfer(input int n, input int b);
      int bsz = 1 << (b == 0 ? 0 : b + 1);
      int rem = n;
      int run = 0;
      int guard = 0;
      int v;
      logic [7:0] c;
      set_count(n);
      set_cfg(1'b1, b);
      while (!eot_irq && guard < 400) begin
         @(negedge clk);
         if (dma_req) begin
            run++;
         end else if (run > 0) begin
            // R6/R7: burst length or single-byte tail
            chk(run == ((rem >= bsz) ? bsz : 1), (rem >= bsz) ? "R6" : "R7",
                run, (rem >= bsz) ? bsz : 1);
            rem -= run;
            run = 0;
         end
         dma_ack = dma_req;
         guard++;
      end
      dma_ack = 1'b0;
      chk(eot_irq, "R9", eot_irq, 1);
      chk(rem == 0, "R9", rem, 0);
      chk(!dma_req, "R9", dma_req, 0);
      get_cfg(c);
      chk(c == {4'b0, 1'b0, 1'b0, 2'(b)}, "R4", c, {4'b0, 2'(b)});
      get_count(v);
      chk(v == 0, "R3", v, 0);
      chk(eot_irq, "R11", eot_irq, 1);
      clear_irq();
      chk(!eot_irq, "R11", eot_irq, 0);
   endtask

   bit finished = 1'b0;

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int v;
      logic [7:0] c;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(!dma_req, "R1", dma_req, 0);
      chk(!eot_irq, "R1", eot_irq, 0);
      get_cfg(c);   chk(c == 8'h00, "R1", c, 0);
      get_count(v); chk(v == 0, "R1", v, 0);

      // R2, R3, R5, R8, R13, R10 directed
      set_count(16'h0A0B - 16'h0A0B + 10);
      set_cfg(1'b1, 0);
      get_count(v); chk(v == 10, "R2", v, 10);
      set_count(16'h1234);
      set_cfg(1'b1, 0);
      get_count(v); chk(v == 16'h1234, "R2", v, 16'h1234);
      set_count(10);
      set_cfg(1'b1, 0);
      ack_bytes(3);
      get_count(v); chk(v == 7, "R8", v, 7);
      set_count(5);
      get_count(v); chk(v == 7, "R13", v, 7);
      set_cfg(1'b1, 0);
      get_count(v); chk(v == 5, "R5", v, 5);
      chk(!eot_irq, "R5", eot_irq, 0);
      set_cfg(1'b0, 0);
      chk(eot_irq, "R10", eot_irq, 1);
      chk(!dma_req, "R10", dma_req, 0);
      get_cfg(c); chk(c == 8'h00, "R10", c, 0);
      clear_irq();
      repeat (5) begin
         @(negedge clk); dma_ack = 1'b1;
      end
      @(negedge clk); dma_ack = 1'b0;
      get_count(v); chk(v == 5, "R8", v, 5);
      set_cfg(1'b0, 0);
      chk(!eot_irq, "R10", eot_irq, 0);

      // R12 bus reset
      set_count(50);
      set_cfg(1'b1, 3);
      ack_bytes(4);
      @(negedge clk); bus_rst = 1'b1;
      @(negedge clk); bus_rst = 1'b0;
      chk(!dma_req, "R12", dma_req, 0);
      chk(!eot_irq, "R12", eot_irq, 0);
      get_cfg(c); chk(c == 8'h03, "R12", c, 3);
      cmd(8'hF0); wr(8'h0B);
      get_count(v); chk(v == 50, "R12", v, 50);
      set_cfg(1'b0, 3);
      clear_irq();

      // R6 R7 R9 sweep
      for (int b = 0; b < 4; b++)
         for (int n = 0; n <= 40; n++)
            transfer(n, b);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule